// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block watches the DRAM command stream and tells a scheduler, one clock at a time, which rank-banks may take a PRECHARGE, which may take an ACTIVATE, and which ranks may take a PRECHARGE-ALL. Each issued command is reported through a strobe with its type, rank and bank. The block keeps one small down-counter for each spacing rule. Some of these counters belong to a single rank-bank and some belong to a whole rank.

A command loads every counter it restricts with a programmable spacing, given in DRAM clocks. A counter that is loaded with value V in cycle t clears in cycle t+V. A permit bit is high only when every counter that guards it has cleared. A spacing of 0 or 1 places no restriction. After reset all counters are clear, so all permits are high.

The block only tracks spacing. It does not issue commands, and it does not check that the commands it is told about are legal.

Top module: `dram_spacing_tracker`

## Requirements
- R1: After a synchronous active-low reset, every bit of pre_ok, act_ok and prea_ok is 1.
- R2: An ACTIVATE (cmd_type 1) issued to a rank-bank in cycle t drives pre_ok for that rank-bank low from cycle t+1 until cycle t+cfg_act_to_pre, when it returns high.
- R3: A WRITE (cmd_type 3) issued in cycle t keeps pre_ok of that rank-bank low until cycle t+cfg_wr_to_pre.
- R4: A READ (cmd_type 2) issued in cycle t keeps pre_ok of that rank-bank low until cycle t+cfg_rd_to_pre.
- R5: An ACTIVATE issued to any bank of a rank in cycle t keeps act_ok low for every bank of that rank until cycle t+cfg_act_to_act.
- R6: A PRECHARGE (cmd_type 4) issued in cycle t keeps act_ok of that rank-bank low until cycle t+cfg_pre_to_act.
- R7: A PRECHARGE-ALL (cmd_type 5) issued in cycle t keeps act_ok of every bank of its rank low until cycle t+max(cfg_prea_to_act, cfg_pre_to_act).
- R8: A REFRESH (cmd_type 6) issued in cycle t keeps act_ok of every bank of its rank low until cycle t+cfg_ref_to_act, where the spacing is 9 bits wide.
- R9: A spacing value of 0 or 1 never lowers a permit.
- R10: A command never lowers a permit that belongs to another rank. A rank-bank rule never lowers a permit of another bank.
- R11: When several rules guard one permit, the permit is the AND of them, so the longest outstanding spacing decides. A repeated command restarts its own spacing.
- R12: prea_ok for a rank is 1 exactly when pre_ok is 1 for all banks of that rank.
- R13: While cmd_valid is 0, or when cmd_type is 0 (no operation), no permit changes. The permit index is rank*NUM_BANKS+bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command issues this cycle |
| cmd_type | input | 3 | 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PRE-ALL, 6 REF |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bank | input | BANK_W | Target bank (ignored for PRE-ALL and REF) |
| cfg_act_to_pre | input | 5 | ACTIVATE to PRECHARGE spacing, same rank-bank |
| cfg_wr_to_pre | input | 5 | WRITE to PRECHARGE spacing, same rank-bank |
| cfg_rd_to_pre | input | 4 | READ to PRECHARGE spacing, same rank-bank |
| cfg_act_to_act | input | 4 | ACTIVATE to ACTIVATE spacing, same rank |
| cfg_pre_to_act | input | 4 | PRECHARGE to ACTIVATE spacing, same rank-bank |
| cfg_prea_to_act | input | 4 | PRECHARGE-ALL to ACTIVATE spacing, same rank |
| cfg_ref_to_act | input | 9 | REFRESH to ACTIVATE spacing, same rank |
| pre_ok | output | NUM_RANKS*NUM_BANKS | PRECHARGE permitted, per rank-bank |
| act_ok | output | NUM_RANKS*NUM_BANKS | ACTIVATE permitted, per rank-bank |
| prea_ok | output | NUM_RANKS | PRECHARGE-ALL permitted, per rank |

## Verification
The bench builds the block with two ranks of four banks. That is the smallest shape in which a rank-wide rule can be told apart from a bank rule, and in which traffic in one rank can be seen not to disturb the other. With these defaults the spacings of every rule differ, so the AND of overlapping rules and the longest-wins outcome are both visible. A refresh spacing of 300 clocks drives the 9-bit counter past its 8-bit range and to its exact release cycle.

// File: rtl/dst_pkg.sv
// Package: shared command encoding for the DRAM spacing tracker.
// Assumes a 3-bit command type field on the issue strobe.
package dst_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;
endpackage

// File: rtl/spacing_counter.sv
// Module: spacing_counter
// Saturating down-counter for one spacing rule. When load is high it takes
// span-1, or 0 when span is 0. Otherwise it counts down to zero and holds there.
// The output clear is high while the count is zero.
// Assumes the span is sampled only in the cycle of load.
module spacing_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] span,
    output logic         clear
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    // Load on a restricting command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (span == '0) ? '0 : span - ONE;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign clear = (cnt == '0);

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> clear);

    // R11
    load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (span > ONE)) |=> !clear);
endmodule

// File: rtl/bank_tracker.sv
// Module: bank_tracker
// Holds the four rules that apply to one rank-bank. ACTIVATE, WRITE and READ
// each restrict a later PRECHARGE. PRECHARGE, or a PRECHARGE-ALL to the
// owning rank, restricts a later ACTIVATE.
// Assumes bank_hit and rank_hit are already qualified by cmd_valid.
module bank_tracker
    import dst_pkg::*;
#(
    parameter int W_ACT_PRE = 5,
    parameter int W_WR_PRE  = 5,
    parameter int W_RD_PRE  = 4,
    parameter int W_PRE_ACT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bank_hit,
    input  logic                 rank_hit,
    input  cmd_e                 cmd,
    input  logic [W_ACT_PRE-1:0] span_act_pre,
    input  logic [W_WR_PRE-1:0]  span_wr_pre,
    input  logic [W_RD_PRE-1:0]  span_rd_pre,
    input  logic [W_PRE_ACT-1:0] span_pre_act,
    output logic                 pre_clear,
    output logic                 act_clear
);
    logic ld_act, ld_wr, ld_rd, ld_pre;
    logic c_act, c_wr, c_rd;

    // Decode which bank counters this command loads.
    always_comb begin
        ld_act = bank_hit && (cmd == CMD_ACT);
        ld_wr  = bank_hit && (cmd == CMD_WR);
        ld_rd  = bank_hit && (cmd == CMD_RD);
        ld_pre = (bank_hit && (cmd == CMD_PRE)) || (rank_hit && (cmd == CMD_PREA));
    end

    spacing_counter #(.W(W_ACT_PRE)) u_act_pre (
        .clk(clk), .rst_n(rst_n), .load(ld_act), .span(span_act_pre), .clear(c_act));
    spacing_counter #(.W(W_WR_PRE)) u_wr_pre (
        .clk(clk), .rst_n(rst_n), .load(ld_wr), .span(span_wr_pre), .clear(c_wr));
    spacing_counter #(.W(W_RD_PRE)) u_rd_pre (
        .clk(clk), .rst_n(rst_n), .load(ld_rd), .span(span_rd_pre), .clear(c_rd));
    spacing_counter #(.W(W_PRE_ACT)) u_pre_act (
        .clk(clk), .rst_n(rst_n), .load(ld_pre), .span(span_pre_act), .clear(act_clear));

    assign pre_clear = c_act && c_wr && c_rd;
endmodule

// File: rtl/rank_tracker.sv
// Module: rank_tracker
// Holds the three rank-wide rules that restrict ACTIVATE to any bank of the
// rank: after ACTIVATE, after PRECHARGE-ALL and after REFRESH.
// Assumes rank_hit is already qualified by cmd_valid.
module rank_tracker
    import dst_pkg::*;
#(
    parameter int W_ACT_ACT  = 4,
    parameter int W_PREA_ACT = 4,
    parameter int W_REF_ACT  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rank_hit,
    input  cmd_e                  cmd,
    input  logic [W_ACT_ACT-1:0]  span_act_act,
    input  logic [W_PREA_ACT-1:0] span_prea_act,
    input  logic [W_REF_ACT-1:0]  span_ref_act,
    output logic                  act_clear
);
    logic ld_act, ld_prea, ld_ref;
    logic c_act, c_prea, c_ref;

    // Decode which rank counters this command loads.
    always_comb begin
        ld_act  = rank_hit && (cmd == CMD_ACT);
        ld_prea = rank_hit && (cmd == CMD_PREA);
        ld_ref  = rank_hit && (cmd == CMD_REF);
    end

    spacing_counter #(.W(W_ACT_ACT)) u_act_act (
        .clk(clk), .rst_n(rst_n), .load(ld_act), .span(span_act_act), .clear(c_act));
    spacing_counter #(.W(W_PREA_ACT)) u_prea_act (
        .clk(clk), .rst_n(rst_n), .load(ld_prea), .span(span_prea_act), .clear(c_prea));
    spacing_counter #(.W(W_REF_ACT)) u_ref_act (
        .clk(clk), .rst_n(rst_n), .load(ld_ref), .span(span_ref_act), .clear(c_ref));

    assign act_clear = c_act && c_prea && c_ref;
endmodule

// File: rtl/dram_spacing_tracker.sv
// Module: dram_spacing_tracker
// Top level. It holds one rank_tracker per rank and one bank_tracker per
// rank-bank, and combines their clear flags into permit bits. The permit
// index is rank*NUM_BANKS+bank.
// Assumes at most one command per clock, and that the spacings stay stable
// while a restriction is pending.
module dram_spacing_tracker
    import dst_pkg::*;
#(
    parameter int NUM_RANKS  = 2,
    parameter int NUM_BANKS  = 4,
    parameter int W_ACT_PRE  = 5,
    parameter int W_WR_PRE   = 5,
    parameter int W_RD_PRE   = 4,
    parameter int W_ACT_ACT  = 4,
    parameter int W_PRE_ACT  = 4,
    parameter int W_PREA_ACT = 4,
    parameter int W_REF_ACT  = 9,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int NRB    = NUM_RANKS * NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_type,
    input  logic [RANK_W-1:0]     cmd_rank,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [W_ACT_PRE-1:0]  cfg_act_to_pre,
    input  logic [W_WR_PRE-1:0]   cfg_wr_to_pre,
    input  logic [W_RD_PRE-1:0]   cfg_rd_to_pre,
    input  logic [W_ACT_ACT-1:0]  cfg_act_to_act,
    input  logic [W_PRE_ACT-1:0]  cfg_pre_to_act,
    input  logic [W_PREA_ACT-1:0] cfg_prea_to_act,
    input  logic [W_REF_ACT-1:0]  cfg_ref_to_act,
    output logic [NRB-1:0]        pre_ok,
    output logic [NRB-1:0]        act_ok,
    output logic [NUM_RANKS-1:0]  prea_ok
);
    cmd_e cmd;

    // Interpret the raw type field as a command.
    always_comb cmd = cmd_e'(cmd_type);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        localparam logic [RANK_W-1:0] RID = RANK_W'(r);
        logic rank_hit;
        logic rank_clear;

        assign rank_hit = cmd_valid && (cmd_rank == RID);

        rank_tracker #(
            .W_ACT_ACT(W_ACT_ACT), .W_PREA_ACT(W_PREA_ACT), .W_REF_ACT(W_REF_ACT)
        ) u_rank (
            .clk(clk), .rst_n(rst_n), .rank_hit(rank_hit), .cmd(cmd),
            .span_act_act(cfg_act_to_act), .span_prea_act(cfg_prea_to_act),
            .span_ref_act(cfg_ref_to_act), .act_clear(rank_clear));

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [BANK_W-1:0] BID = BANK_W'(b);
            localparam int IDX = r * NUM_BANKS + b;
            logic bank_hit;
            logic bank_act_clear;

            assign bank_hit = rank_hit && (cmd_bank == BID);

            bank_tracker #(
                .W_ACT_PRE(W_ACT_PRE), .W_WR_PRE(W_WR_PRE),
                .W_RD_PRE(W_RD_PRE), .W_PRE_ACT(W_PRE_ACT)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .bank_hit(bank_hit), .rank_hit(rank_hit),
                .cmd(cmd), .span_act_pre(cfg_act_to_pre), .span_wr_pre(cfg_wr_to_pre),
                .span_rd_pre(cfg_rd_to_pre), .span_pre_act(cfg_pre_to_act),
                .pre_clear(pre_ok[IDX]), .act_clear(bank_act_clear));

            assign act_ok[IDX] = bank_act_clear && rank_clear;

            // R10
            pre_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pre_ok[IDX]) |-> $past(cmd_valid && cmd_rank == RID && cmd_bank == BID
                    && (cmd_type == 3'd1 || cmd_type == 3'd2 || cmd_type == 3'd3)));

            // R13
            act_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(act_ok[IDX]) |-> $past(cmd_valid && cmd_rank == RID
                    && (cmd_type == 3'd1 || cmd_type == 3'd4 || cmd_type == 3'd5
                        || cmd_type == 3'd6)));
        end

        assign prea_ok[r] = &pre_ok[r*NUM_BANKS +: NUM_BANKS];
    end
endmodule

// File: tb/dram_spacing_tracker_tb.sv
module dram_spacing_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 2;
    localparam int NB = 4;
    localparam int NRB = NR * NB;
    localparam longint NEVER = -100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_type = 3'd0;
    logic [0:0] cmd_rank = '0;
    logic [1:0] cmd_bank = '0;
    logic [4:0] cfg_act_to_pre = 5'd6;
    logic [4:0] cfg_wr_to_pre = 5'd9;
    logic [3:0] cfg_rd_to_pre = 4'd3;
    logic [3:0] cfg_act_to_act = 4'd4;
    logic [3:0] cfg_pre_to_act = 4'd5;
    logic [3:0] cfg_prea_to_act = 4'd7;
    logic [8:0] cfg_ref_to_act = 9'd20;
    logic [NRB-1:0] pre_ok, act_ok;
    logic [NR-1:0] prea_ok;

    int checks = 0;
    int failures = 0;
    longint n = 0;
    longint l_act[NRB], l_wr[NRB], l_rd[NRB], l_pre[NRB];
    longint l_actr[NR], l_prea[NR], l_ref[NR];

    // Vector: [15:12] requirement, [11] valid, [10:8] type, [7:4] rank, [3:0] bank
    localparam int NV = 28;
    localparam logic [15:0] VEC [NV] = '{
        16'h2901, 16'h0000, 16'h0000, 16'h4A01,   // R2 ACT r0b1, R4 RD r0b1
        16'h3B01, 16'hA912, 16'h5903, 16'h0000,   // R3 WR, R10 ACT r1b2, R5 ACT r0b3
        16'h0000, 16'h0000, 16'h0000, 16'h6C01,   // R6 PRE r0b1
        16'h0000, 16'h0000, 16'h7D10, 16'h0000,   // R7 PRE-ALL r1
        16'h0000, 16'h8E00, 16'h0000, 16'h0000,   // R8 REF r0
        16'hB901, 16'h0000, 16'hB901, 16'h0000,   // R11 repeated ACT r0b1
        16'hCB12, 16'h0000, 16'hD110, 16'h0000    // R12 WR r1b2, R13 valid low
    };

    dram_spacing_tracker #(.NUM_RANKS(NR), .NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
        .cfg_act_to_pre(cfg_act_to_pre), .cfg_wr_to_pre(cfg_wr_to_pre),
        .cfg_rd_to_pre(cfg_rd_to_pre), .cfg_act_to_act(cfg_act_to_act),
        .cfg_pre_to_act(cfg_pre_to_act), .cfg_prea_to_act(cfg_prea_to_act),
        .cfg_ref_to_act(cfg_ref_to_act), .pre_ok(pre_ok), .act_ok(act_ok),
        .prea_ok(prea_ok));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit okv(longint s, int v);
        return (n - s + 1) >= v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NRB; i++) begin
            l_act[i] = NEVER; l_wr[i] = NEVER; l_rd[i] = NEVER; l_pre[i] = NEVER;
        end
        for (int r = 0; r < NR; r++) begin
            l_actr[r] = NEVER; l_prea[r] = NEVER; l_ref[r] = NEVER;
        end
    endtask

    task automatic chk(bit cond, string req, longint act_v, longint exp_v);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (step %0d)", req, act_v, exp_v, n);
        end
    endtask

    // Compare every output with the timestamp model.
    task automatic check_model(string req);
        logic [NRB-1:0] ep, ea;
        logic [NR-1:0] eq;
        for (int i = 0; i < NRB; i++) begin
            int r = i / NB;
            ep[i] = okv(l_act[i], int'(cfg_act_to_pre)) && okv(l_wr[i], int'(cfg_wr_to_pre))
                  && okv(l_rd[i], int'(cfg_rd_to_pre));
            ea[i] = okv(l_pre[i], int'(cfg_pre_to_act)) && okv(l_actr[r], int'(cfg_act_to_act))
                  && okv(l_prea[r], int'(cfg_prea_to_act)) && okv(l_ref[r], int'(cfg_ref_to_act));
        end
        for (int r = 0; r < NR; r++) eq[r] = &ep[r*NB +: NB];
        chk({prea_ok, act_ok, pre_ok} === {eq, ea, ep}, req,
            longint'({prea_ok, act_ok, pre_ok}), longint'({eq, ea, ep}));
    endtask

    task automatic step(bit v, logic [2:0] t, int r, int b);
        @(negedge clk);
        cmd_valid = v; cmd_type = t; cmd_rank = 1'(r); cmd_bank = 2'(b);
        @(posedge clk);
        #1;
        n++;
        if (v) begin
            int i = r * NB + b;
            case (t)
                3'd1: begin l_act[i] = n; l_actr[r] = n; end
                3'd2: l_rd[i] = n;
                3'd3: l_wr[i] = n;
                3'd4: l_pre[i] = n;
                3'd5: begin
                    l_prea[r] = n;
                    for (int k = 0; k < NB; k++) l_pre[r*NB + k] = n;
                end
                3'd6: l_ref[r] = n;
                default: ;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        n = 0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1: all permits high after reset
        chk({prea_ok, act_ok, pre_ok} === '1, "R1", longint'({prea_ok, act_ok, pre_ok}), 18'h3FFFF);

        // Table walk, checked against the model every step
        for (int k = 0; k < NV; k++) begin
            logic [15:0] e = VEC[k];
            step(e[11], e[10:8], int'(e[7:4]), int'(e[3:0]));
            check_model($sformatf("R%0d table entry %0d", e[15:12], k));
        end
        for (int k = 0; k < 25; k++) begin
            step(1'b0, 3'd0, 0, 0);
            check_model("R10 drain");
        end

        // R2: exact release cycle of ACT->PRE (spacing 6)
        step(1'b1, 3'd1, 0, 0);
        for (int k = 0; k < 4; k++) step(1'b0, 3'd0, 0, 0);
        chk(pre_ok[0] == 1'b0, "R2 still blocked", pre_ok[0], 0);
        chk(prea_ok[0] == 1'b0, "R12 rank blocked", prea_ok[0], 0);
        chk(prea_ok[1] == 1'b1, "R10 other rank", prea_ok[1], 1);
        step(1'b0, 3'd0, 0, 0);
        chk(pre_ok[0] == 1'b1, "R2 released", pre_ok[0], 1);
        for (int k = 0; k < 10; k++) step(1'b0, 3'd0, 0, 0);

        // R13: valid low and NOP do not change permits
        step(1'b0, 3'd1, 1, 1);
        chk(act_ok[5] && pre_ok[5], "R13 valid low", {act_ok[5], pre_ok[5]}, 2'b11);
        step(1'b1, 3'd0, 1, 1);
        chk({act_ok, pre_ok} === '1, "R13 nop", longint'({act_ok, pre_ok}), 16'hFFFF);

        // R9: spacing 0 and 1 never block
        cfg_act_to_pre = 5'd0; cfg_act_to_act = 4'd1; cfg_pre_to_act = 4'd0;
        cfg_prea_to_act = 4'd1; cfg_ref_to_act = 9'd0; cfg_wr_to_pre = 5'd1;
        cfg_rd_to_pre = 4'd0;
        do_reset();
        step(1'b1, 3'd1, 0, 2);
        chk({act_ok, pre_ok} === '1, "R9 act", longint'({act_ok, pre_ok}), 16'hFFFF);
        step(1'b1, 3'd5, 1, 0);
        chk({act_ok, pre_ok} === '1, "R9 prea", longint'({act_ok, pre_ok}), 16'hFFFF);
        step(1'b1, 3'd3, 1, 3);
        chk({act_ok, pre_ok} === '1, "R9 wr", longint'({act_ok, pre_ok}), 16'hFFFF);

        // R8: 9-bit refresh spacing of 300 clocks
        cfg_ref_to_act = 9'd300;
        do_reset();
        step(1'b1, 3'd6, 1, 0);
        chk(act_ok[7:4] == 4'h0 && act_ok[3:0] == 4'hF, "R8 blocks rank 1 only",
            act_ok, 8'h0F);
        for (int k = 0; k < 298; k++) step(1'b0, 3'd0, 0, 0);
        chk(act_ok[7:4] == 4'h0, "R8 still blocked at 299", act_ok[7:4], 0);
        step(1'b0, 3'd0, 0, 0);
        chk(act_ok[7:4] == 4'hF, "R8 released at 300", act_ok[7:4], 4'hF);

        // R7: PRE-ALL with pre_to_act longer than prea_to_act
        cfg_pre_to_act = 4'd9; cfg_prea_to_act = 4'd3;
        do_reset();
        step(1'b1, 3'd5, 0, 0);
        for (int k = 0; k < 7; k++) step(1'b0, 3'd0, 0, 0);
        chk(act_ok[3:0] == 4'h0, "R7 longer rule holds", act_ok[3:0], 0);
        step(1'b0, 3'd0, 0, 0);
        chk(act_ok[3:0] == 4'hF, "R7 released", act_ok[3:0], 4'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule